// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block predicts whether a conditional branch will be taken. It holds two direction predictors that look at different kinds of history, plus a selector that learns, branch by branch, which of the two to believe. The global component uses the recent outcomes of all branches, joined with a few low PC bits, to pick a 2-bit saturating counter. The local component first looks up the branch's own recent outcomes in a per-branch history table, then uses that pattern to pick a 2-bit counter. A table of 2-bit selector counters, indexed by PC, chooses which component's answer goes out.

Fetch presents a PC on the lookup port and receives the taken bit in the same cycle, together with the two component answers. Later, when the branch resolves, the pipeline returns the PC, the real outcome and the two component answers it was given. Each update changes the tables at the next clock edge. The lookup logic is purely combinational and reads registered tables only. Target addresses, history repair after a flush and multiple branches per cycle are not handled here.

Top module: `tourney_bp`

## Requirements
- R1: After reset every counter holds 1 (weakly not taken) and every history register holds zero. As a result, `pred_taken`, `pred_global` and `pred_local` are all 0 for any PC.
- R2: Every counter is 2 bits wide and saturates at 0 and 3. Values 2 and 3 mean taken. A taken outcome adds one and a not-taken outcome subtracts one, so a strongly biased counter changes its direction only after two wrong outcomes in a row.
- R3: In the default variant (`GLOBAL_HASH`=0), the global counter index is `{pc[GPC_W-1:0], ghr}`. The global history `ghr` is `HIST_W` bits wide. On each update it shifts left and takes the real outcome in at bit 0.
- R4: The local history table is indexed by `pc[LHT_IDX_W-1:0]`. Its entry selects one of `2**HIST_W` local counters. On update, that entry shifts left and takes the outcome in at bit 0.
- R5: The selector table is indexed by `pc[CHO_IDX_W-1:0]`. A selector value of 2 or 3 chooses the local component; 0 or 1 chooses the global one. A selector counter changes only when exactly one component answer matched the outcome. It steps toward local when the local answer was right, and toward global when the global answer was right.
- R6: `pred_taken` equals the answer of the component that the selector chooses. It responds combinationally to `pred_pc` within the same cycle.
- R7: When `upd_valid` is low, no table or history changes, whatever the other update inputs carry.
- R8: An update uses the counter indices formed from the histories as they stood before that update. Its effect appears on the lookup outputs only after the next rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pred_pc | input | PC_W | PC of the branch being looked up |
| pred_taken | output | 1 | Final direction prediction |
| pred_global | output | 1 | Global component answer for `pred_pc` |
| pred_local | output | 1 | Local component answer for `pred_pc` |
| upd_valid | input | 1 | Resolved-branch update strobe |
| upd_pc | input | PC_W | PC of the resolved branch |
| upd_taken | input | 1 | Real outcome of the resolved branch |
| upd_global_pred | input | 1 | Global answer given at lookup time |
| upd_local_pred | input | 1 | Local answer given at lookup time |

## Verification
The bench builds the block with its defaults: a 16-bit PC, 4 history bits, 2 PC bits concatenated into the global index, and 16-entry local history and selector tables. These small tables mean that short branch streams saturate counters, fill histories and alias branches onto shared entries. A loop-style branch, an alternating branch and a branch that follows a neighbour therefore drive the selector in both directions within a few dozen updates. A reference model built from the requirements follows every update. Directed runs cover reset, saturation at both ends, updates held off by `upd_valid`, and the one-edge delay before an update becomes visible.

// File: rtl/tbp_pkg.sv
package tbp_pkg;

   typedef logic [1:0] ctr2_t;

   localparam ctr2_t CTR_RESET = 2'd1;

   function automatic ctr2_t ctr_step(input ctr2_t c, input logic up);
      ctr2_t n;
      if (up) n = (c == 2'd3) ? c : c + 2'd1;
      else    n = (c == 2'd0) ? c : c - 2'd1;
      return n;
   endfunction

   function automatic logic ctr_dir(input ctr2_t c);
      return c[1];
   endfunction

endpackage

// File: rtl/tbp_ctr_tab.sv
module tbp_ctr_tab
   import tbp_pkg::*;
#(
   parameter int IDX_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] rd_idx,
   output ctr2_t            rd_ctr,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic             wr_up
);
   localparam int DEPTH = 1 << IDX_W;

   if (IDX_W < 1 || IDX_W > 12) begin : g_bad_idx
      $error("tbp_ctr_tab: IDX_W out of range");
   end

   ctr2_t cells [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) cells[i] <= CTR_RESET;
      end else if (wr_en) begin
         cells[wr_idx] <= ctr_step(cells[wr_idx], wr_up);
      end
   end

   assign rd_ctr = cells[rd_idx];
endmodule

// File: rtl/tbp_hist_tab.sv
module tbp_hist_tab #(
   parameter int IDX_W  = 4,
   parameter int HIST_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [HIST_W-1:0] rd_hist,
   input  logic [IDX_W-1:0]  up_idx,
   output logic [HIST_W-1:0] up_hist,
   input  logic              up_en,
   input  logic              up_bit
);
   localparam int DEPTH = 1 << IDX_W;

   if (IDX_W < 1 || IDX_W > 12) begin : g_bad_idx
      $error("tbp_hist_tab: IDX_W out of range");
   end
   if (HIST_W < 2) begin : g_bad_hist
      $error("tbp_hist_tab: HIST_W must be at least 2");
   end

   logic [HIST_W-1:0] rows [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) rows[i] <= '0;
      end else if (up_en) begin
         rows[up_idx] <= {rows[up_idx][HIST_W-2:0], up_bit};
      end
   end

   assign rd_hist = rows[rd_idx];
   assign up_hist = rows[up_idx];
endmodule

// File: rtl/tbp_ghr.sv
module tbp_ghr #(
   parameter int HIST_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              up_en,
   input  logic              up_bit,
   output logic [HIST_W-1:0] hist
);
   if (HIST_W < 2) begin : g_bad_hist
      $error("tbp_ghr: HIST_W must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     hist <= '0;
      else if (up_en) hist <= {hist[HIST_W-2:0], up_bit};
   end
endmodule

// File: rtl/tourney_bp.sv
module tourney_bp
   import tbp_pkg::*;
#(
   parameter int PC_W        = 16,
   parameter int HIST_W      = 4,
   parameter int GPC_W       = 2,
   parameter int GLOBAL_HASH = 0,
   parameter int LHT_IDX_W   = 4,
   parameter int CHO_IDX_W   = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [PC_W-1:0] pred_pc,
   output logic            pred_taken,
   output logic            pred_global,
   output logic            pred_local,
   input  logic            upd_valid,
   input  logic [PC_W-1:0] upd_pc,
   input  logic            upd_taken,
   input  logic            upd_global_pred,
   input  logic            upd_local_pred
);
   localparam int GIDX_W = (GLOBAL_HASH == 0) ? (GPC_W + HIST_W) : HIST_W;

   if (HIST_W < 2) begin : g_bad_hist
      $error("tourney_bp: HIST_W must be at least 2");
   end
   if (GLOBAL_HASH != 0 && GLOBAL_HASH != 1) begin : g_bad_hash
      $error("tourney_bp: GLOBAL_HASH must be 0 (concat) or 1 (xor)");
   end
   if (GLOBAL_HASH == 0 && (GPC_W < 1 || GPC_W > PC_W)) begin : g_bad_gpc
      $error("tourney_bp: GPC_W out of range");
   end
   if (GLOBAL_HASH == 1 && HIST_W > PC_W) begin : g_bad_xor
      $error("tourney_bp: HIST_W exceeds PC_W for xor hashing");
   end
   if (LHT_IDX_W > PC_W || CHO_IDX_W > PC_W) begin : g_bad_idx
      $error("tourney_bp: table index wider than PC");
   end

   logic [HIST_W-1:0] ghr;
   logic [GIDX_W-1:0] gidx_p, gidx_u;
   logic [HIST_W-1:0] lhist_p, lhist_u;
   ctr2_t             gctr_p, lctr_p, cctr_p;
   logic              g_ok, l_ok, cho_wr;

   // Global index variant
   if (GLOBAL_HASH == 0) begin : g_concat
      assign gidx_p = {pred_pc[GPC_W-1:0], ghr};
      assign gidx_u = {upd_pc[GPC_W-1:0], ghr};
   end else begin : g_xor
      assign gidx_p = pred_pc[HIST_W-1:0] ^ ghr;
      assign gidx_u = upd_pc[HIST_W-1:0] ^ ghr;
   end

   tbp_ghr #(.HIST_W(HIST_W)) u_ghr (
      .clk    (clk),
      .rst_n  (rst_n),
      .up_en  (upd_valid),
      .up_bit (upd_taken),
      .hist   (ghr)
   );

   tbp_ctr_tab #(.IDX_W(GIDX_W)) u_gtab (
      .clk    (clk),
      .rst_n  (rst_n),
      .rd_idx (gidx_p),
      .rd_ctr (gctr_p),
      .wr_en  (upd_valid),
      .wr_idx (gidx_u),
      .wr_up  (upd_taken)
   );

   tbp_hist_tab #(.IDX_W(LHT_IDX_W), .HIST_W(HIST_W)) u_lht (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_idx  (pred_pc[LHT_IDX_W-1:0]),
      .rd_hist (lhist_p),
      .up_idx  (upd_pc[LHT_IDX_W-1:0]),
      .up_hist (lhist_u),
      .up_en   (upd_valid),
      .up_bit  (upd_taken)
   );

   tbp_ctr_tab #(.IDX_W(HIST_W)) u_ltab (
      .clk    (clk),
      .rst_n  (rst_n),
      .rd_idx (lhist_p),
      .rd_ctr (lctr_p),
      .wr_en  (upd_valid),
      .wr_idx (lhist_u),
      .wr_up  (upd_taken)
   );

   // Selector learns only when the components disagree in correctness
   assign g_ok   = (upd_global_pred == upd_taken);
   assign l_ok   = (upd_local_pred == upd_taken);
   assign cho_wr = upd_valid && (g_ok ^ l_ok);

   tbp_ctr_tab #(.IDX_W(CHO_IDX_W)) u_ctab (
      .clk    (clk),
      .rst_n  (rst_n),
      .rd_idx (pred_pc[CHO_IDX_W-1:0]),
      .rd_ctr (cctr_p),
      .wr_en  (cho_wr),
      .wr_idx (upd_pc[CHO_IDX_W-1:0]),
      .wr_up  (l_ok)
   );

   assign pred_global = ctr_dir(gctr_p);
   assign pred_local  = ctr_dir(lctr_p);
   assign pred_taken  = ctr_dir(cctr_p) ? pred_local : pred_global;
endmodule

// File: rtl/tbp_checker.sv
module tbp_checker #(
   parameter int HIST_W = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              upd_valid,
   input logic              upd_taken,
   input logic              pred_taken,
   input logic              pred_global,
   input logic              pred_local,
   input logic [HIST_W-1:0] ghr
);
   AST_RESET_GHR_ZERO: assert property (@(posedge clk) !rst_n |=> ghr == '0); // R1

   AST_GHR_SHIFT_IN: assert property (@(posedge clk) disable iff (!rst_n)
      upd_valid |=> (ghr[0] == $past(upd_taken)) &&
                    (ghr[HIST_W-1:1] == $past(ghr[HIST_W-2:0]))); // R3

   AST_IDLE_GHR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !upd_valid |=> $stable(ghr)); // R7

   AST_AGREE_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
      (pred_global == pred_local) |-> (pred_taken == pred_global)); // R6
endmodule

bind tourney_bp tbp_checker #(.HIST_W(HIST_W)) u_tbp_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .upd_valid   (upd_valid),
   .upd_taken   (upd_taken),
   .pred_taken  (pred_taken),
   .pred_global (pred_global),
   .pred_local  (pred_local),
   .ghr         (ghr)
);

// File: tb/tourney_bp_test.sv
`timescale 1ns/1ps
module tourney_bp_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] pred_pc = '0;
   logic        pred_taken, pred_global, pred_local;
   logic        upd_valid = 1'b0;
   logic [15:0] upd_pc = '0;
   logic        upd_taken = 1'b0;
   logic        upd_global_pred = 1'b0;
   logic        upd_local_pred = 1'b0;

   int checks = 0;
   int fails  = 0;

   always #2.5 clk = ~clk;

   tourney_bp uut (
      .clk             (clk),
      .rst_n           (rst_n),
      .pred_pc         (pred_pc),
      .pred_taken      (pred_taken),
      .pred_global     (pred_global),
      .pred_local      (pred_local),
      .upd_valid       (upd_valid),
      .upd_pc          (upd_pc),
      .upd_taken       (upd_taken),
      .upd_global_pred (upd_global_pred),
      .upd_local_pred  (upd_local_pred)
   );

   // Reference state built from the requirements
   logic [1:0] m_g [64];
   logic [1:0] m_l [16];
   logic [1:0] m_c [16];
   logic [3:0] m_lht [16];
   logic [3:0] m_ghr;

   function automatic logic [1:0] sat(input logic [1:0] c, input logic up);
      if (up) return (c == 2'd3) ? c : c + 2'd1;
      return (c == 2'd0) ? c : c - 2'd1;
   endfunction

   task automatic model_reset();
      for (int i = 0; i < 64; i++) m_g[i] = 2'd1;
      for (int i = 0; i < 16; i++) begin
         m_l[i] = 2'd1; m_c[i] = 2'd1; m_lht[i] = '0;
      end
      m_ghr = '0;
   endtask

   task automatic model_pred(input logic [15:0] pc, output logic g, output logic l,
                             output logic p);
      g = m_g[{pc[1:0], m_ghr}][1];
      l = m_l[m_lht[pc[3:0]]][1];
      p = m_c[pc[3:0]][1] ? l : g;
   endtask

   task automatic model_update(input logic [15:0] pc, input logic tk,
                               input logic g, input logic l);
      logic [5:0] gi;
      logic [3:0] li;
      gi = {pc[1:0], m_ghr};
      li = m_lht[pc[3:0]];
      m_g[gi] = sat(m_g[gi], tk);
      m_l[li] = sat(m_l[li], tk);
      if ((g == tk) != (l == tk)) m_c[pc[3:0]] = sat(m_c[pc[3:0]], l == tk);
      m_ghr = {m_ghr[2:0], tk};
      m_lht[pc[3:0]] = {m_lht[pc[3:0]][2:0], tk};
   endtask

   task automatic chk(input string req, input string what, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; upd_valid = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      model_reset();
   endtask

   // One lookup followed by its resolving update
   task automatic step(input logic [15:0] pc, input logic tk);
      logic g, l, p;
      @(negedge clk);
      pred_pc = pc;
      #0.5;
      model_pred(pc, g, l, p);
      chk("R2/R3", "global answer", pred_global, g);
      chk("R4", "local answer", pred_local, l);
      chk("R5/R6", "final answer", pred_taken, p);
      upd_pc = pc; upd_taken = tk; upd_global_pred = g; upd_local_pred = l;
      upd_valid = 1'b1;
      #0.5;
      chk("R8", "no change before edge", pred_taken, p);
      @(posedge clk);
      model_update(pc, tk, g, l);
      #0.5;
      upd_valid = 1'b0;
   endtask

   // Stimulus table: {pc, outcome}
   localparam logic [16:0] VEC [32] = '{
      {16'h0010,1'b1},{16'h0010,1'b1},{16'h0010,1'b1},{16'h0010,1'b0},
      {16'h0025,1'b1},{16'h0025,1'b0},{16'h0025,1'b1},{16'h0025,1'b0},
      {16'h0010,1'b1},{16'h0010,1'b1},{16'h0010,1'b1},{16'h0010,1'b0},
      {16'h0033,1'b1},{16'h0047,1'b1},{16'h0033,1'b0},{16'h0047,1'b0},
      {16'h0033,1'b1},{16'h0047,1'b1},{16'h0033,1'b0},{16'h0047,1'b0},
      {16'h0025,1'b1},{16'h0025,1'b0},{16'h0025,1'b1},{16'h0025,1'b0},
      {16'h1110,1'b0},{16'h0010,1'b1},{16'h1110,1'b0},{16'h0010,1'b1},
      {16'h0008,1'b1},{16'h0008,1'b1},{16'h0008,1'b1},{16'h0008,1'b1}
   };

   initial begin : watchdog
      #1000000;
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin : main
      logic g, l, p;
      model_reset();
      do_reset();

      // R1: reset state for several PCs
      for (int k = 0; k < 4; k++) begin
         @(negedge clk);
         pred_pc = 16'h1234 + 16'(k * 37);
         #0.5;
         chk("R1", "reset final", pred_taken, 1'b0);
         chk("R1", "reset global", pred_global, 1'b0);
         chk("R1", "reset local", pred_local, 1'b0);
      end

      // Table walk, repeated so the selector and histories train
      for (int pass = 0; pass < 4; pass++)
         for (int v = 0; v < 32; v++) step(VEC[v][16:1], VEC[v][0]);

      // R7: update inputs active but valid low must not touch state
      @(negedge clk);
      pred_pc = 16'h0010;
      upd_pc = 16'h0010; upd_taken = 1'b1;
      upd_global_pred = 1'b0; upd_local_pred = 1'b1;
      upd_valid = 1'b0;
      repeat (6) begin
         @(negedge clk);
         upd_taken = ~upd_taken;
      end
      #0.5;
      model_pred(16'h0010, g, l, p);
      chk("R7", "global after idle", pred_global, g);
      chk("R7", "local after idle", pred_local, l);
      chk("R7", "final after idle", pred_taken, p);
      step(16'h0010, 1'b1);

      // R2: saturation at 0 then two taken outcomes before flip
      do_reset();
      for (int i = 0; i < 5; i++) step(16'h0100, 1'b0);
      for (int i = 0; i < 6; i++) step(16'h0100, 1'b1);
      for (int i = 0; i < 6; i++) step(16'h0100, 1'b0);

      // R5: selector pulled toward local by a pattern only local sees
      do_reset();
      for (int r = 0; r < 6; r++) begin
         step(16'h0005, 1'b1);
         step(16'h0005, 1'b0);
         step(16'h000A, 1'b0);
         step(16'h000A, 1'b0);
      end

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule